// File: doc/BRIEF.md
# Vectored Interrupt Controller with Non-Maskable Path

This block gathers up to 32 level-sensitive interrupt lines for a small processor core. The lower lines feed a raw pending word. A software-owned enable word gates that word into a masked pending word. From the masked word the block drives one interrupt request wire and an 8-bit vector bus.

When exactly one enabled source is pending, the vector names that source. When two or more are pending, the vector takes a single shared value, and the interrupt handler reads the masked pending word and picks the order itself. The topmost lines skip the mask entirely. They drive a separate non-maskable request through their own status word.

Software reaches the state through a plain 32-bit bus with byte addresses. Reads are combinational. The enable word is the only state that software can write.

Top module: `ivc_top`

## Requirements
- R1: The register index is byte address bits [ADDR_W-1:2]; bits [1:0] are ignored. The index values and what a read returns are:
  - 0: enable mask.
  - 1: raw pending word.
  - 2: masked pending word.
  - 3: non-maskable status word.
  - 4: always zero.
  - Any index of 5 or more: zero.
  - The read data reflects the current state combinationally.
- R2: While reset is low, and after it, all state is zero, `int_req` and `nmi_req` are low, `int_vec` is 0, and every word reads as zero.
- R3: A write with index 0 stores `bus_wdata` as the mask at the clock edge. A write with any other index leaves the mask and all other state unchanged.
- R4: `masked_pend` and word 2 always equal the raw pending word ANDed with the mask.
- R5: When exactly one bit i of `masked_pend` is set, `int_req` is 1 and `int_vec` is 0x31 + i.
- R6: When two or more bits of `masked_pend` are set, `int_req` is 1 and `int_vec` is 0x30.
- R7: When `masked_pend` is zero, `int_req` is 0 and `int_vec` is 0.
- R8: Line n, for n from 1 to 29, is sampled at every rising edge into raw bit n-1 and follows the line level, with no latching. Raw bits 29 to 31 are always 0.
- R9: Lines 30 and 31 never reach the raw word. Each line is sampled into its own bit (30 or 31) of the non-maskable status word and follows its level.
- R10: `nmi_req` is 1 exactly when any status bit is set, whatever the mask holds.
- R11: Line 0 has no effect on any output or register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| irq_lines | input | 32 | Level-sensitive interrupt lines |
| bus_addr | input | 8 | Byte address for reads and writes |
| bus_wr | input | 1 | Write strobe, sampled at the clock edge |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Combinational read data |
| masked_pend | output | 32 | Raw pending word ANDed with the mask |
| int_req | output | 1 | Maskable interrupt request |
| int_vec | output | 8 | Vector: 0 when idle, 0x30 when shared, 0x31+i for a single source |
| nmi_req | output | 1 | Non-maskable request |

## Verification
The hardest cases to reach from the ports are the ones where the mask decides between the single-source vector and the shared vector while several raw lines stay high.

The stimulus first raises two or more lines together. It then rewrites only the mask, so the same raw pattern produces a shared vector, a single-source vector and silence in turn.

The non-maskable lines are driven together with a zero mask. This shows that `nmi_req` rises while `int_req` stays low.

// File: rtl/ivc_pkg.sv
package ivc_pkg;
   localparam int unsigned REG_WORDS = 5;
   typedef enum logic [2:0] {
      RG_MASK   = 3'd0,
      RG_RAW    = 3'd1,
      RG_MASKED = 3'd2,
      RG_NMI    = 3'd3,
      RG_RSVD   = 3'd4
   } ivc_reg_e;
endpackage

// File: rtl/ivc_line_sampler.sv
module ivc_line_sampler #(
   parameter int N_LINES   = 32,
   parameter int NMI_FIRST = 30
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic [N_LINES-1:0] lines,
   output logic [N_LINES-1:0] raw_q,
   output logic [N_LINES-1:0] nmi_q
);
   logic [N_LINES-1:0] raw_nxt;
   logic [N_LINES-1:0] nmi_nxt;
   logic               unused_line0;

   assign unused_line0 = lines[0];

   for (genvar j = 0; j < N_LINES; j++) begin : g_map
      // raw bit j is fed by line j+1, but only below the non-maskable range
      if (j + 1 < NMI_FIRST) begin : g_raw
         assign raw_nxt[j] = lines[j+1];
      end else begin : g_raw_off
         assign raw_nxt[j] = 1'b0;
      end
      if (j >= NMI_FIRST) begin : g_nmi
         assign nmi_nxt[j] = lines[j];
      end else begin : g_nmi_off
         assign nmi_nxt[j] = 1'b0;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         raw_q <= '0;
         nmi_q <= '0;
      end else begin
         raw_q <= raw_nxt;
         nmi_q <= nmi_nxt;
      end
   end
endmodule

// File: rtl/ivc_vec_encode.sv
module ivc_vec_encode #(
   parameter int          N_LINES    = 32,
   parameter int          VEC_W      = 8,
   parameter logic [7:0]  VEC_SHARED = 8'h30,
   parameter logic [7:0]  VEC_BASE   = 8'h31,
   parameter bit          OR_TREE    = 1'b1
) (
   input  logic [N_LINES-1:0] pend,
   output logic               req,
   output logic [VEC_W-1:0]   vec
);
   localparam int IDX_W = $clog2(N_LINES);

   logic             any;
   logic             multi;
   logic [IDX_W-1:0] idx;

   assign any   = |pend;
   assign multi = |(pend & (pend - N_LINES'(1)));

   if (OR_TREE) begin : g_or_tree
      // valid only for a one-hot input, which is the only case that uses idx
      logic [IDX_W-1:0][N_LINES-1:0] sel;
      for (genvar b = 0; b < IDX_W; b++) begin : g_bit
         for (genvar i = 0; i < N_LINES; i++) begin : g_src
            if (((i >> b) & 1) == 1) begin : g_on
               assign sel[b][i] = pend[i];
            end else begin : g_off
               assign sel[b][i] = 1'b0;
            end
         end
         assign idx[b] = |sel[b];
      end
   end else begin : g_scan
      always_comb begin
         idx = '0;
         for (int i = N_LINES - 1; i >= 0; i--) begin
            if (pend[i]) idx = IDX_W'(i);
         end
      end
   end

   always_comb begin
      if (!any) begin
         req = 1'b0;
         vec = '0;
      end else if (multi) begin
         req = 1'b1;
         vec = VEC_W'(VEC_SHARED);
      end else begin
         req = 1'b1;
         vec = VEC_W'(VEC_BASE) + {{(VEC_W-IDX_W){1'b0}}, idx};
      end
   end
endmodule

// File: rtl/ivc_regfile.sv
module ivc_regfile
   import ivc_pkg::*;
#(
   parameter int DATA_W = 32,
   parameter int ADDR_W = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [ADDR_W-1:0] bus_addr,
   input  logic              bus_wr,
   input  logic [DATA_W-1:0] bus_wdata,
   input  logic [DATA_W-1:0] raw_q,
   input  logic [DATA_W-1:0] masked,
   input  logic [DATA_W-1:0] nmi_q,
   output logic [DATA_W-1:0] mask_q,
   output logic [DATA_W-1:0] bus_rdata
);
   localparam int IDX_W = ADDR_W - 2;

   logic [IDX_W-1:0] idx;
   logic             in_range;
   ivc_reg_e         sel;

   assign idx      = bus_addr[ADDR_W-1:2];
   assign in_range = idx < IDX_W'(REG_WORDS);
   assign sel      = ivc_reg_e'(idx[2:0]);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         mask_q <= '0;
      end else if (bus_wr && in_range && sel == RG_MASK) begin
         mask_q <= bus_wdata;
      end
   end

   always_comb begin
      bus_rdata = '0;
      if (in_range) begin
         case (sel)
            RG_MASK:   bus_rdata = mask_q;
            RG_RAW:    bus_rdata = raw_q;
            RG_MASKED: bus_rdata = masked;
            RG_NMI:    bus_rdata = nmi_q;
            default:   bus_rdata = '0;
         endcase
      end
   end
endmodule

// File: rtl/ivc_top.sv
module ivc_top #(
   parameter int         N_LINES    = 32,
   parameter int         DATA_W     = 32,
   parameter int         ADDR_W     = 8,
   parameter int         VEC_W      = 8,
   parameter int         NMI_FIRST  = 30,
   parameter logic [7:0] VEC_SHARED = 8'h30,
   parameter logic [7:0] VEC_BASE   = 8'h31,
   parameter bit         OR_TREE    = 1'b1
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic [N_LINES-1:0] irq_lines,
   input  logic [ADDR_W-1:0]  bus_addr,
   input  logic               bus_wr,
   input  logic [DATA_W-1:0]  bus_wdata,
   output logic [DATA_W-1:0]  bus_rdata,
   output logic [N_LINES-1:0] masked_pend,
   output logic               int_req,
   output logic [VEC_W-1:0]   int_vec,
   output logic               nmi_req
);
   if (N_LINES != DATA_W) begin : g_bad_width
      $error("ivc_top: N_LINES must equal DATA_W");
   end
   if (NMI_FIRST < 2 || NMI_FIRST > N_LINES) begin : g_bad_nmi
      $error("ivc_top: NMI_FIRST out of range");
   end
   if (ADDR_W < 5) begin : g_bad_addr
      $error("ivc_top: ADDR_W too small for five words");
   end
   if (VEC_W <= $clog2(N_LINES)) begin : g_bad_vec
      $error("ivc_top: VEC_W too narrow");
   end

   logic [N_LINES-1:0] raw_q;
   logic [N_LINES-1:0] nmi_q;
   logic [DATA_W-1:0]  mask_q;

   ivc_line_sampler #(.N_LINES(N_LINES), .NMI_FIRST(NMI_FIRST)) u_sampler (
      .clk   (clk),
      .rst_n (rst_n),
      .lines (irq_lines),
      .raw_q (raw_q),
      .nmi_q (nmi_q)
   );

   assign masked_pend = raw_q & mask_q;
   assign nmi_req     = |nmi_q;

   ivc_vec_encode #(
      .N_LINES(N_LINES), .VEC_W(VEC_W), .VEC_SHARED(VEC_SHARED),
      .VEC_BASE(VEC_BASE), .OR_TREE(OR_TREE)
   ) u_encode (
      .pend (masked_pend),
      .req  (int_req),
      .vec  (int_vec)
   );

   ivc_regfile #(.DATA_W(DATA_W), .ADDR_W(ADDR_W)) u_regs (
      .clk       (clk),
      .rst_n     (rst_n),
      .bus_addr  (bus_addr),
      .bus_wr    (bus_wr),
      .bus_wdata (bus_wdata),
      .raw_q     (raw_q),
      .masked    (masked_pend),
      .nmi_q     (nmi_q),
      .mask_q    (mask_q),
      .bus_rdata (bus_rdata)
   );
endmodule

// File: rtl/ivc_checker.sv
module ivc_checker #(
   parameter int         N_LINES    = 32,
   parameter int         ADDR_W     = 8,
   parameter int         VEC_W      = 8,
   parameter int         NMI_FIRST  = 30,
   parameter logic [7:0] VEC_SHARED = 8'h30,
   parameter logic [7:0] VEC_BASE   = 8'h31
) (
   input logic               clk,
   input logic               rst_n,
   input logic [N_LINES-1:0] irq_lines,
   input logic [ADDR_W-1:0]  bus_addr,
   input logic               bus_wr,
   input logic [N_LINES-1:0] bus_wdata,
   input logic [N_LINES-1:0] mask_q,
   input logic [N_LINES-1:0] masked_pend,
   input logic               int_req,
   input logic [VEC_W-1:0]   int_vec,
   input logic               nmi_req
);
   // R3
   mask_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_wr && bus_addr[ADDR_W-1:2] == '0) |=> mask_q == $past(bus_wdata));
   // R3
   ro_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_wr && bus_addr[ADDR_W-1:2] != '0) |=> $stable(mask_q));
   // R5
   single_vec_chk: assert property (@(posedge clk) disable iff (!rst_n)
      ($countones(masked_pend) == 1) |-> (int_req && int_vec >= VEC_W'(VEC_BASE)));
   // R6
   shared_vec_chk: assert property (@(posedge clk) disable iff (!rst_n)
      ($countones(masked_pend) > 1) |-> (int_req && int_vec == VEC_W'(VEC_SHARED)));
   // R7
   idle_vec_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (masked_pend == '0) |-> (!int_req && int_vec == '0));
   // R8
   level_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
      1'b1 |=> masked_pend[0] == ($past(irq_lines[1]) && mask_q[0]));
   // R9
   nmi_isolated_chk: assert property (@(posedge clk) disable iff (!rst_n)
      masked_pend[N_LINES-1:NMI_FIRST-1] == '0);
   // R10
   nmi_raise_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (|irq_lines[N_LINES-1:NMI_FIRST]) |=> nmi_req);
   // R10
   nmi_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !(|irq_lines[N_LINES-1:NMI_FIRST]) |=> !nmi_req);
endmodule

bind ivc_top ivc_checker #(
   .N_LINES(N_LINES), .ADDR_W(ADDR_W), .VEC_W(VEC_W), .NMI_FIRST(NMI_FIRST),
   .VEC_SHARED(VEC_SHARED), .VEC_BASE(VEC_BASE)
) u_chk (
   .clk(clk), .rst_n(rst_n), .irq_lines(irq_lines), .bus_addr(bus_addr),
   .bus_wr(bus_wr), .bus_wdata(bus_wdata), .mask_q(mask_q),
   .masked_pend(masked_pend), .int_req(int_req), .int_vec(int_vec),
   .nmi_req(nmi_req)
);

// File: tb/tb_ivc_top.sv
module tb_ivc_top;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [31:0] irq_lines = '0;
   logic [7:0]  bus_addr = '0;
   logic        bus_wr = 1'b0;
   logic [31:0] bus_wdata = '0;
   logic [31:0] bus_rdata;
   logic [31:0] masked_pend;
   logic        int_req;
   logic [7:0]  int_vec;
   logic        nmi_req;

   int n_tests = 0;
   int n_fail  = 0;

   always #10 clk = ~clk;

   ivc_top dut (
      .clk(clk), .rst_n(rst_n), .irq_lines(irq_lines), .bus_addr(bus_addr),
      .bus_wr(bus_wr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
      .masked_pend(masked_pend), .int_req(int_req), .int_vec(int_vec),
      .nmi_req(nmi_req)
   );

   localparam int NV = 10;
   localparam logic [31:0] T_LINES [NV] = '{32'h0000_0002, 32'h2000_0000,
      32'h0000_0006, 32'h0000_0006, 32'h0000_0006, 32'h0000_0001,
      32'h4000_0000, 32'h8000_0002, 32'hFFFF_FFFF, 32'h0000_0400};
   localparam logic [31:0] T_MASK [NV] = '{32'hFFFF_FFFF, 32'hFFFF_FFFF,
      32'hFFFF_FFFF, 32'h0000_0002, 32'h0000_0000, 32'hFFFF_FFFF,
      32'hFFFF_FFFF, 32'h0000_0000, 32'hFFFF_FFFF, 32'h0000_0200};
   localparam logic [7:0] T_VEC [NV] = '{8'h31, 8'h4D, 8'h30, 8'h32, 8'h00,
      8'h00, 8'h00, 8'h00, 8'h30, 8'h3A};
   localparam logic T_REQ [NV] = '{1'b1, 1'b1, 1'b1, 1'b1, 1'b0, 1'b0, 1'b0,
      1'b0, 1'b1, 1'b1};
   localparam logic T_NMI [NV] = '{1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b1,
      1'b1, 1'b1, 1'b0};

   function automatic logic [31:0] model_masked(input logic [31:0] l, input logic [31:0] m);
      return ((l >> 1) & 32'h1FFF_FFFF) & m;
   endfunction

   task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
      n_tests++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s actual=%h expected=%h", tag, act, exp);
      end
   endtask

   // called just after a falling edge; inputs held over one rising edge
   task automatic step(input logic [31:0] lines, input logic wr,
                       input logic [7:0] addr, input logic [31:0] data);
      irq_lines = lines;
      bus_wr    = wr;
      bus_addr  = addr;
      bus_wdata = data;
      @(posedge clk);
      @(negedge clk);
      bus_wr = 1'b0;
   endtask

   task automatic rd(input logic [7:0] addr, input logic [31:0] exp, input string tag);
      bus_addr = addr;
      #1;
      chk(tag, bus_rdata, exp);
   endtask

   initial begin
      #(20 * 100000);
      n_fail++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
   end

   initial begin
      irq_lines = 32'hFFFF_FFFF;
      repeat (3) @(negedge clk);
      // R2 reset state while lines are active
      chk("R2 req in reset", {31'b0, int_req}, 32'd0);
      chk("R2 nmi in reset", {31'b0, nmi_req}, 32'd0);
      chk("R2 vec in reset", {24'b0, int_vec}, 32'd0);
      rd(8'h04, 32'd0, "R2 raw word in reset");
      rd(8'h0C, 32'd0, "R2 nmi word in reset");
      irq_lines = '0;
      rst_n = 1'b1;
      @(negedge clk);
      rd(8'h00, 32'd0, "R2 mask after reset");

      // table walk: R4 R5 R6 R7 R9 R10 R11
      for (int k = 0; k < NV; k++) begin
         step(T_LINES[k], 1'b1, 8'h00, T_MASK[k]);
         chk($sformatf("R5/R6/R7 vec row %0d", k), {24'b0, int_vec}, {24'b0, T_VEC[k]});
         chk($sformatf("R5/R6/R7 req row %0d", k), {31'b0, int_req}, {31'b0, T_REQ[k]});
         chk($sformatf("R10 nmi row %0d", k), {31'b0, nmi_req}, {31'b0, T_NMI[k]});
         chk($sformatf("R4 masked row %0d", k), masked_pend, model_masked(T_LINES[k], T_MASK[k]));
      end

      // state after last full-on style: all lines high, full mask
      step(32'hFFFF_FFFF, 1'b1, 8'h00, 32'hFFFF_FFFF);
      rd(8'h04, 32'h1FFF_FFFF, "R8 raw word top bits zero");
      rd(8'h0C, 32'hC000_0000, "R9 nmi status bits");
      rd(8'h08, 32'h1FFF_FFFF, "R4 masked word");
      rd(8'h10, 32'd0, "R1 reserved word");
      rd(8'h14, 32'd0, "R1 out of range");
      rd(8'h03, 32'hFFFF_FFFF, "R1 low address bits ignored");

      // R3 writes to read-only and out-of-range indices
      step(32'hFFFF_FFFF, 1'b1, 8'h04, 32'h0000_0000);
      rd(8'h00, 32'hFFFF_FFFF, "R3 write to raw word ignored");
      rd(8'h04, 32'h1FFF_FFFF, "R3 raw word untouched");
      step(32'hFFFF_FFFF, 1'b1, 8'h40, 32'h0000_0000);
      rd(8'h00, 32'hFFFF_FFFF, "R3 out-of-range write ignored");
      chk("R3 vec after ignored write", {24'b0, int_vec}, 32'h30);

      // R6 -> R5 -> R7 via mask only, lines held (bits 3 and 7 -> lines 4 and 8)
      step(32'h0000_0110, 1'b1, 8'h00, 32'h0000_0088);
      chk("R6 two enabled", {24'b0, int_vec}, 32'h30);
      step(32'h0000_0110, 1'b1, 8'h00, 32'h0000_0080);
      chk("R5 single via mask", {24'b0, int_vec}, 32'h38);
      step(32'h0000_0110, 1'b1, 8'h00, 32'h0000_0000);
      chk("R7 mask cleared req", {31'b0, int_req}, 32'd0);

      // R8 level follow: drop the line, pending clears without any write
      step(32'h0000_0002, 1'b1, 8'h00, 32'hFFFF_FFFF);
      chk("R8 line high", {24'b0, int_vec}, 32'h31);
      step(32'h0000_0000, 1'b0, 8'h00, 32'h0);
      chk("R8 line low clears", {31'b0, int_req}, 32'd0);
      rd(8'h04, 32'd0, "R8 raw word cleared");

      // R11 line 0 alone, full mask
      step(32'h0000_0001, 1'b0, 8'h00, 32'h0);
      rd(8'h04, 32'd0, "R11 line0 raw");
      chk("R11 line0 req", {31'b0, int_req}, 32'd0);

      // R10 nmi ignores mask; R9 nmi bit clears with level
      step(32'h8000_0000, 1'b1, 8'h00, 32'h0);
      chk("R10 nmi with zero mask", {31'b0, nmi_req}, 32'd1);
      chk("R9 no maskable req", {31'b0, int_req}, 32'd0);
      step(32'h0000_0000, 1'b0, 8'h00, 32'h0);
      chk("R9 nmi clears", {31'b0, nmi_req}, 32'd0);

      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
   end
endmodule